// File: doc/BRIEF.md
# Four-Mode General-Purpose Pin Port

This block controls a port of general-purpose pins, one per bit, behind a small strobe-based register interface. Each pin has its own two-bit mode field that selects one of four electrical behaviours: quasi-bidirectional with a weak pull-up, full push-pull output, high-impedance input, or open-drain. A write strobe loads the output latch and a separate write strobe loads the mode register. Both can be given in the same cycle.

For every pin the block produces a drive-enable, a drive-value and a weak-pull-up request. The pad can therefore be modelled outside the block with tri-state and pull elements. Pin levels come back through a two-flop synchroniser. A read strobe returns a word whose bits come from the output latch or from the synchronised pin, depending on each pin's mode. Several open-drain pins can share one pulled-up net and form a wired-AND.

Top module: `gpio_quad_port`

## Requirements
- R1: Pin i takes its mode from bits [2i+1:2i] of the mode register, encoded as 2'b00 quasi-bidirectional, 2'b01 push-pull, 2'b10 high-impedance input and 2'b11 open-drain. Different pins may hold different modes at the same time.
- R2: In push-pull mode the pin is always driven (`drv_en`=1), `drv_val` equals the latched bit, and no pull-up is requested.
- R3: In open-drain mode a latched 0 drives the pin low (`drv_en`=1, `drv_val`=0). A latched 1 releases the pin (`drv_en`=0). No pull-up is requested in this mode.
- R4: In high-impedance input mode `drv_en`, `drv_val` and `pull_req` are all 0, whatever the latch holds.
- R5: In quasi-bidirectional mode a latched 0 drives the pin low without a pull-up. A latched 1 releases the pin and asserts `pull_req`.
- R6: While `rd_en` is 1, `rdata` bit i returns the latched bit for pins in push-pull or open-drain mode, and the synchronised pin level for pins in quasi-bidirectional or high-impedance mode.
- R7: While `rd_en` is 0, `rdata` is all zeros.
- R8: A synchronous active-low reset sets the output latch to all ones and every mode field to high-impedance input, so no pin drives or pulls after reset.
- R9: A change on `pin_in` appears on `rdata` after exactly two rising clock edges, not after one.
- R10: The output latch changes only on an edge where `wr_data_en` is 1, and the mode register only on an edge where `wr_mode_en` is 1. The new values act on the drive outputs from that edge on. When both strobes are given in one cycle, both values apply together.
- R11: When several open-drain pins share one net with an external pull-up, the net equals the AND of their latched bits, and readback still reports each pin's own latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_data_en | input | 1 | Write strobe for the output latch |
| wdata | input | NPINS | New output latch value |
| wr_mode_en | input | 1 | Write strobe for the mode register |
| wmode | input | 2*NPINS | New mode fields, two bits per pin |
| rd_en | input | 1 | Read strobe; gates `rdata` |
| rdata | output | NPINS | Readback word, zero when not reading |
| pin_in | input | NPINS | Pad levels from outside, asynchronous |
| drv_en | output | NPINS | Pad driver enable per pin |
| drv_val | output | NPINS | Pad driver value per pin |
| pull_req | output | NPINS | Weak pull-up request per pin |

## Verification
A wrong mode field shows at the drive and pull outputs on the first edge after the write that should have set it. A latch bit that is stuck or wrongly loaded shows at once on `drv_val` or `drv_en` for driving modes, and on readback for push-pull and open-drain modes. A synchroniser with the wrong number of stages shows as a readback that updates one edge early or late, so the bench samples both the first and the second edge after a pin change. The shared open-drain net exposes readback that wrongly takes the pin instead of the latch, because the net and the latch differ in that test.

// File: rtl/gpio_quad_pkg.sv
// Package: shared mode encoding for the four-mode pin port.
// Assumes two bits per pin mode field; the encoding is fixed by R1.
package gpio_quad_pkg;

    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        PM_QUASI = 2'b00,
        PM_PUSH  = 2'b01,
        PM_HIZ   = 2'b10,
        PM_OPEN  = 2'b11
    } pin_mode_e;

endpackage

// File: rtl/gpio_sync2.sv
// Module: two-flop synchroniser for the pin inputs.
// Assumes pin_in is asynchronous to clk; output lags two edges.
module gpio_sync2 #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_sync
);

    logic [NPINS-1:0] meta_q;
    logic [NPINS-1:0] sync_q;

    // Shift the pin levels through two flop stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= pin_in;
            sync_q <= meta_q;
        end
    end

    assign pin_sync = sync_q;

    // R9
    first_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (meta_q == $past(pin_in)));

    // R9
    second_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (sync_q == $past(meta_q)));

endmodule

// File: rtl/gpio_cfg_regs.sv
// Module: output latch and per-pin mode register.
// Assumes strobes are single-cycle or level; each loads on every edge it is high.
module gpio_cfg_regs
    import gpio_quad_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_data_en,
    input  logic [NPINS-1:0]        wdata,
    input  logic                    wr_mode_en,
    input  logic [NPINS*MODE_W-1:0] wmode,
    output logic [NPINS-1:0]        lat_q,
    output logic [NPINS*MODE_W-1:0] mode_q
);

    localparam logic [NPINS*MODE_W-1:0] MODE_RST = {NPINS{PM_HIZ}};

    // Load the output latch on its write strobe; reset to all ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q <= '1;
        end else if (wr_data_en) begin
            lat_q <= wdata;
        end
    end

    // Load the mode fields on their write strobe; reset to input mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_RST;
        end else if (wr_mode_en) begin
            mode_q <= wmode;
        end
    end

    // R10
    latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data_en |=> (lat_q == $past(wdata)));

    // R10
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_data_en && !wr_mode_en) |=> ($stable(lat_q) && $stable(mode_q)));

    // R8
    reset_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> ((lat_q == '1) && (mode_q == MODE_RST)));

endmodule

// File: rtl/gpio_pin_ctrl.sv
// Module: per-pin mode decode into pad controls and readback source.
// Assumes mode and latch come from registers, so its outputs are glitch-free after an edge.
module gpio_pin_ctrl
    import gpio_quad_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic              lat,
    input  logic              pin_s,
    output logic              drv_en,
    output logic              drv_val,
    output logic              pull_req,
    output logic              rd_bit
);

    pin_mode_e mode_e;
    assign mode_e = pin_mode_e'(mode);

    // Decode the mode into driver, pull-up and readback selection.
    always_comb begin
        drv_en   = 1'b0;
        drv_val  = 1'b0;
        pull_req = 1'b0;
        rd_bit   = pin_s;
        case (mode_e)
            PM_QUASI: begin
                drv_en   = ~lat;
                pull_req = lat;
            end
            PM_PUSH: begin
                drv_en  = 1'b1;
                drv_val = lat;
                rd_bit  = lat;
            end
            PM_HIZ: begin
                rd_bit = pin_s;
            end
            PM_OPEN: begin
                drv_en = ~lat;
                rd_bit = lat;
            end
            default: begin
                drv_en = 1'b0;
            end
        endcase
    end

    // R3 R5
    pull_vs_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pull_req |-> (!drv_en && (mode_e == PM_QUASI)));

    // R2
    high_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drv_val |-> (drv_en && lat && (mode_e == PM_PUSH)));

    // R4
    hiz_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_e == PM_HIZ) |-> (!drv_en && !pull_req));

endmodule

// File: rtl/gpio_quad_port.sv
// Module: top of the four-mode pin port.
// Assumes the pad is modelled outside from drv_en/drv_val/pull_req and fed back on pin_in.
module gpio_quad_port
    import gpio_quad_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_data_en,
    input  logic [NPINS-1:0]        wdata,
    input  logic                    wr_mode_en,
    input  logic [NPINS*MODE_W-1:0] wmode,
    input  logic                    rd_en,
    output logic [NPINS-1:0]        rdata,
    input  logic [NPINS-1:0]        pin_in,
    output logic [NPINS-1:0]        drv_en,
    output logic [NPINS-1:0]        drv_val,
    output logic [NPINS-1:0]        pull_req
);

    logic [NPINS-1:0]        lat_q;
    logic [NPINS*MODE_W-1:0] mode_q;
    logic [NPINS-1:0]        pin_sync;
    logic [NPINS-1:0]        rd_bits;

    gpio_cfg_regs #(.NPINS(NPINS)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_data_en (wr_data_en),
        .wdata      (wdata),
        .wr_mode_en (wr_mode_en),
        .wmode      (wmode),
        .lat_q      (lat_q),
        .mode_q     (mode_q)
    );

    gpio_sync2 #(.NPINS(NPINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .pin_sync (pin_sync)
    );

    for (genvar gi = 0; gi < NPINS; gi++) begin : g_pin
        gpio_pin_ctrl u_ctrl (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode     (mode_q[gi*MODE_W +: MODE_W]),
            .lat      (lat_q[gi]),
            .pin_s    (pin_sync[gi]),
            .drv_en   (drv_en[gi]),
            .drv_val  (drv_val[gi]),
            .pull_req (pull_req[gi]),
            .rd_bit   (rd_bits[gi])
        );
    end

    // Gate the readback word with the read strobe.
    always_comb begin
        rdata = rd_en ? rd_bits : '0;
    end

    // R7
    read_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rdata == '0));

endmodule

// File: tb/gpio_quad_port_test.sv
module gpio_quad_port_test;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_data_en = 1'b0;
    logic [N-1:0] wdata = '0;
    logic         wr_mode_en = 1'b0;
    logic [2*N-1:0] wmode = '0;
    logic         rd_en = 1'b0;
    logic [N-1:0] rdata;
    logic [N-1:0] pin_in;
    logic [N-1:0] drv_en;
    logic [N-1:0] drv_val;
    logic [N-1:0] pull_req;

    logic [N-1:0] ext = '0;
    logic         wired_on = 1'b0;
    logic         net;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_quad_port #(.NPINS(N)) uut (
        .clk(clk), .rst_n(rst_n),
        .wr_data_en(wr_data_en), .wdata(wdata),
        .wr_mode_en(wr_mode_en), .wmode(wmode),
        .rd_en(rd_en), .rdata(rdata),
        .pin_in(pin_in),
        .drv_en(drv_en), .drv_val(drv_val), .pull_req(pull_req)
    );

    // Pad model: a driver wins over the outside level; pins 0..3 may share a pulled-up net.
    always_comb begin
        net = &(~drv_en[3:0] | drv_val[3:0]);
        for (int i = 0; i < N; i++) begin
            pin_in[i] = drv_en[i] ? drv_val[i] : ext[i];
            if (wired_on && i < 4) pin_in[i] = net;
        end
    end

    task automatic chk(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // {mode16, data, ext, exp_en, exp_val, exp_pull, exp_rd}
    localparam logic [63:0] VEC [8] = '{
        {16'h0000, 8'hF0, 8'h5A, 8'h0F, 8'h00, 8'hF0, 8'h50},
        {16'h5555, 8'hA5, 8'h3C, 8'hFF, 8'hA5, 8'h00, 8'hA5},
        {16'hAAAA, 8'h00, 8'hC3, 8'h00, 8'h00, 8'h00, 8'hC3},
        {16'hFFFF, 8'h96, 8'hFF, 8'h69, 8'h00, 8'h00, 8'h96},
        {16'h0000, 8'hFF, 8'h81, 8'h00, 8'h00, 8'hFF, 8'h81},
        {16'h5555, 8'h00, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00},
        {16'hE4E4, 8'h5A, 8'hF0, 8'hA3, 8'h02, 8'h10, 8'h5A},
        {16'hFFFF, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF}
    };

    initial begin
        tick(); tick();
        // R8 reset state while held in reset and just after release
        chk("R8 drv_en in reset", drv_en, 8'h00);
        chk("R8 pull_req in reset", pull_req, 8'h00);
        chk("R7 rdata idle", rdata, 8'h00);
        rst_n = 1'b1;
        ext = 8'h3C;
        rd_en = 1'b1;
        tick(); tick(); tick();
        chk("R8 input mode after reset reads pins", rdata, 8'h3C);

        // Table: both strobes together each time (R10); modes R1..R6
        for (int v = 0; v < 8; v++) begin
            wmode = VEC[v][63:48];
            wdata = VEC[v][47:40];
            ext   = VEC[v][39:32];
            wr_mode_en = 1'b1;
            wr_data_en = 1'b1;
            tick();
            wr_mode_en = 1'b0;
            wr_data_en = 1'b0;
            tick(); tick();
            chk($sformatf("R1 R2 R3 R4 R5 drv_en vec%0d", v), drv_en, VEC[v][31:24]);
            chk($sformatf("R2 R3 drv_val vec%0d", v), drv_val, VEC[v][23:16]);
            chk($sformatf("R5 pull_req vec%0d", v), pull_req, VEC[v][15:8]);
            chk($sformatf("R6 rdata vec%0d", v), rdata, VEC[v][7:0]);
        end

        // R10 mode write alone acts only after its edge; latch still FF
        wmode = 16'h5555;
        wr_mode_en = 1'b1;
        #1;
        chk("R10 before edge drv_en", drv_en, 8'h00);
        tick();
        wr_mode_en = 1'b0;
        chk("R10 after edge drv_en", drv_en, 8'hFF);
        chk("R10 after edge drv_val", drv_val, 8'hFF);

        // R10 latch ignores wdata without its strobe
        wdata = 8'h00;
        wmode = 16'h0000;
        tick(); tick();
        chk("R10 no strobe drv_val", drv_val, 8'hFF);
        chk("R10 no strobe drv_en", drv_en, 8'hFF);

        // R7 read strobe low gives zero even with latch FF in push-pull
        rd_en = 1'b0;
        #1;
        chk("R7 rdata gated", rdata, 8'h00);
        rd_en = 1'b1;

        // R9 two-edge synchroniser latency in input mode
        wmode = 16'hAAAA;
        wr_mode_en = 1'b1;
        ext = 8'h00;
        tick();
        wr_mode_en = 1'b0;
        tick(); tick();
        chk("R9 settled low", rdata, 8'h00);
        ext = 8'hE7;
        tick();
        chk("R9 one edge still old", rdata, 8'h00);
        tick();
        chk("R9 two edges new", rdata, 8'hE7);

        // R8 mid-run reset, then push-pull without a data write shows latch of ones
        wdata = 8'h12;
        wr_data_en = 1'b1;
        tick();
        wr_data_en = 1'b0;
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        chk("R8 reset drv_en", drv_en, 8'h00);
        wmode = 16'h5555;
        wr_mode_en = 1'b1;
        tick();
        wr_mode_en = 1'b0;
        chk("R8 latch ones after reset", drv_val, 8'hFF);

        // R11 wired-AND: pins 0..2 open-drain, pin 3 input watching the net
        ext = 8'h00;
        wired_on = 1'b1;
        for (int p = 0; p < 8; p++) begin
            logic [2:0] l;
            logic       e;
            l = p[2:0];
            e = &l;
            wmode = 16'hAABF;
            wdata = {5'b0, l};
            wr_mode_en = 1'b1;
            wr_data_en = 1'b1;
            tick();
            wr_mode_en = 1'b0;
            wr_data_en = 1'b0;
            tick(); tick();
            chk($sformatf("R11 net lat=%b", l), {7'b0, net}, {7'b0, e});
            chk($sformatf("R11 readback lat=%b", l), rdata, {4'h0, e, l});
        end
        wired_on = 1'b0;

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule